// File: doc/BRIEF.md
# Interleaved Video Memory Address Translator

This block sits between a requester that sees video memory as a linear window with 64-bit rows and an 8 MB physical store built from two 32-bit banks of 4 MB each. In the linear view, consecutive 32-bit words sit in alternate banks. The address bit that picks the bank becomes the most significant bit of the physical address. For each command (a byte, halfword or word access, or a 32-byte burst) the block emits a sequence of beats. Each beat carries the physical word address and a byte-lane mask. Unaligned head bytes and partial tail bytes each get their own beat. A transfer is cut short so that it never runs past the end of the 8 MB space.

Write commands also produce an invalidate strobe for every 4 KB page of the untranslated window that the transfer touches, so that a texture cache can discard stale lines. A separate read-return path takes a physical word from memory and returns the selected byte or halfword sign-extended to 32 bits.

Top module: `v64_vram_xlate`

## Requirements
- R1: After reset, cmd_ready is 1 and beat_valid, inv_valid, done and rx_valid are all 0.
- R2: Command address bits 31..23 are ignored. The 23-bit address a is used as given.
- R3: Each beat's word address is {a[2], a[22:3]} for the word that holds its bytes, so bank = beat_waddr[20] = a[2].
- R4: The command kinds move 1 byte (0), 2 bytes (1), 4 bytes (2) or 32 bytes (3). An access that crosses a word boundary splits into one beat per word, in ascending address order.
- R5: Successive beats of one command address the opposite bank from the beat before.
- R6: The first beat covers the lanes from a[1:0] upward, up to lane 3 or the end of the transfer. beat_be bit i stands for byte offset i within the physical word.
- R7: A trailing partial word is a final beat covering lanes 0..n-1, where n is the number of remaining bytes.
- R8: A transfer whose end would exceed 0x800000 is shortened to end exactly at 0x800000.
- R9: A beat holds its fields while beat_ready is low. The final beat has beat_last=1. done pulses for one cycle in the cycle after the final beat is accepted, and cmd_ready is 0 while beats are pending.
- R10: A write command pulses inv_valid once for each 4 KB page of the untranslated address range it covers, in ascending order. inv_page = a[22:12]. The first pulse comes with the first beat. Read commands never pulse it.
- R11: One cycle after rd_valid, rx_valid rises. rx_data is then one of three things. Kind 0 gives rd_word byte rd_lane, sign-extended. Kind 1 gives the halfword selected by rd_lane[1] (0 for the low half, 1 for the high half), sign-extended. Kind 2 or 3 gives rd_word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 2 | 0 byte, 1 halfword, 2 word, 3 burst |
| cmd_addr | input | 32 | Linear-window byte address |
| cmd_write | input | 1 | 1 for write, 0 for read |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Beat accepted when high with beat_valid |
| beat_waddr | output | 21 | Physical word address, bank in the MSB |
| beat_be | output | 4 | Byte lanes used in this word |
| beat_last | output | 1 | Final beat of the command |
| beat_write | output | 1 | Direction of the command |
| inv_valid | output | 1 | Page invalidate strobe |
| inv_page | output | 11 | Untranslated 4 KB page number |
| done | output | 1 | One-cycle pulse after the final beat |
| rd_valid | input | 1 | Memory read word present |
| rd_kind | input | 2 | Size of the original read |
| rd_lane | input | 2 | Byte offset of the read within the word |
| rd_word | input | 32 | Physical word from memory |
| rx_valid | output | 1 | Extended read data valid |
| rx_data | output | 32 | Sign-extended read data |

## Verification
The assertions assume three things about the inputs: cmd_valid is only relevant while cmd_ready is high, rd_kind holds its value in the cycle it is sampled, and beat_ready may follow any pattern. The stimulus offers each command only while cmd_ready is high and then withdraws it. It drives beat_ready from a pseudo-random sequence so that beats stall in many positions. It gives halfword read returns only even lanes. Addresses are chosen to cross word, page and end-of-memory boundaries, and some carry junk in the high bits.

// File: rtl/v64_xlate_pkg.sv
package v64_xlate_pkg;
  localparam int V64_BURST_BYTES = 32;
  localparam int V64_LEN_W = $clog2(V64_BURST_BYTES + 1);

  typedef enum logic [1:0] {
    K_BYTE  = 2'd0,
    K_HALF  = 2'd1,
    K_WORD  = 2'd2,
    K_BURST = 2'd3
  } v64_kind_e;

  function automatic logic [V64_LEN_W-1:0] kind_len(v64_kind_e k);
    case (k)
      K_BYTE:  kind_len = V64_LEN_W'(1);
      K_HALF:  kind_len = V64_LEN_W'(2);
      K_WORD:  kind_len = V64_LEN_W'(4);
      default: kind_len = V64_LEN_W'(V64_BURST_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/v64_lane_calc.sv
module v64_lane_calc #(
  parameter int ADDR_W = 23,
  parameter int LEN_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  rem,
  output logic [ADDR_W-3:0] waddr,
  output logic [3:0]        be,
  output logic [LEN_W-1:0]  rem_after,
  output logic [ADDR_W-1:0] addr_after
);
  logic [2:0] avail;
  logic [2:0] take;
  logic [3:0] mask;

  always_comb begin
    avail = 3'd4 - {1'b0, addr[1:0]};
    take  = (rem < LEN_W'(avail)) ? rem[2:0] : avail;
    mask  = 4'((5'd1 << take) - 5'd1);
    be    = mask << addr[1:0];
    rem_after  = rem - LEN_W'(take);
    addr_after = {addr[ADDR_W-1:2] + (ADDR_W-2)'(1), 2'b00};
    // bank select bit moves to the top of the physical word address
    waddr = {addr[2], addr[ADDR_W-1:3]};
  end
endmodule

// File: rtl/v64_beat_gen.sv
module v64_beat_gen #(
  parameter int ADDR_W = 23,
  parameter int LEN_W  = 6,
  parameter int PAGE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [LEN_W-1:0]         cmd_len,
  input  logic                     cmd_write,
  output logic                     beat_valid,
  input  logic                     beat_ready,
  output logic [ADDR_W-3:0]        beat_waddr,
  output logic [3:0]               beat_be,
  output logic                     beat_last,
  output logic                     beat_write,
  output logic                     inv_valid,
  output logic [ADDR_W-PAGE_W-1:0] inv_page,
  output logic                     done
);
  localparam int XW = ADDR_W + 1;

  logic [ADDR_W-1:0] nxt_addr;
  logic [LEN_W-1:0]  nxt_rem;
  logic [XW-1:0]     room;
  logic [XW-1:0]     len_ext;
  logic [LEN_W-1:0]  rem0;
  logic              load_cmd, fire, adv;
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  src_rem;
  logic              src_wr;
  logic [ADDR_W-3:0] c_waddr;
  logic [3:0]        c_be;
  logic [LEN_W-1:0]  c_rem_after;
  logic [ADDR_W-1:0] c_addr_after;

  assign cmd_ready = !beat_valid;
  assign load_cmd  = cmd_valid && cmd_ready;
  assign fire      = beat_valid && beat_ready;
  assign adv       = fire && !beat_last;

  always_comb begin
    room    = {1'b1, {ADDR_W{1'b0}}} - {1'b0, cmd_addr};
    len_ext = {{(XW-LEN_W){1'b0}}, cmd_len};
    rem0    = (len_ext > room) ? room[LEN_W-1:0] : cmd_len;
    src_addr = load_cmd ? cmd_addr : nxt_addr;
    src_rem  = load_cmd ? rem0 : nxt_rem;
    src_wr   = load_cmd ? cmd_write : beat_write;
  end

  v64_lane_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) calc_i (
    .addr       (src_addr),
    .rem        (src_rem),
    .waddr      (c_waddr),
    .be         (c_be),
    .rem_after  (c_rem_after),
    .addr_after (c_addr_after)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_waddr <= '0;
      beat_be    <= '0;
      beat_last  <= 1'b0;
      beat_write <= 1'b0;
      nxt_addr   <= '0;
      nxt_rem    <= '0;
      inv_valid  <= 1'b0;
      inv_page   <= '0;
      done       <= 1'b0;
    end else begin
      done      <= fire && beat_last;
      inv_valid <= 1'b0;
      if (load_cmd || adv) begin
        beat_valid <= 1'b1;
        beat_waddr <= c_waddr;
        beat_be    <= c_be;
        beat_last  <= (c_rem_after == '0);
        beat_write <= src_wr;
        nxt_addr   <= c_addr_after;
        nxt_rem    <= c_rem_after;
        inv_valid  <= src_wr && (load_cmd || (src_addr[PAGE_W-1:0] == '0));
        inv_page   <= src_addr[ADDR_W-1:PAGE_W];
      end else if (fire) begin
        beat_valid <= 1'b0;
      end
    end
  end

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_be != 4'b0000)); // R6
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_waddr) && $stable(beat_be) && $stable(beat_last))); // R9
  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last) |=> (beat_valid && (beat_waddr[ADDR_W-3] != $past(beat_waddr[ADDR_W-3])))); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(beat_valid && beat_ready && beat_last)); // R9
  AST_INV_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (beat_valid && beat_write)); // R10
endmodule

// File: rtl/v64_sext.sv
module v64_sext #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [1:0]        rd_kind,
  input  logic [1:0]        rd_lane,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  import v64_xlate_pkg::*;

  logic [7:0]        byte_sel;
  logic [15:0]       half_sel;
  logic [DATA_W-1:0] ext;

  always_comb begin
    byte_sel = rd_word[{rd_lane, 3'b000} +: 8];
    half_sel = rd_lane[1] ? rd_word[31:16] : rd_word[15:0];
    case (v64_kind_e'(rd_kind))
      K_BYTE:  ext = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
      K_HALF:  ext = {{(DATA_W-16){half_sel[15]}}, half_sel};
      default: ext = rd_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= rd_valid;
      if (rd_valid) rx_data <= ext;
    end
  end

  AST_RX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rd_valid)); // R11
  AST_BYTE_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_kind == 2'd0) |=> (rx_data[DATA_W-1:8] == {(DATA_W-8){rx_data[7]}})); // R11
endmodule

// File: rtl/v64_vram_xlate.sv
module v64_vram_xlate #(
  parameter int ADDR_W = 23,
  parameter int PAGE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_kind,
  input  logic [31:0]              cmd_addr,
  input  logic                     cmd_write,
  output logic                     beat_valid,
  input  logic                     beat_ready,
  output logic [ADDR_W-3:0]        beat_waddr,
  output logic [3:0]               beat_be,
  output logic                     beat_last,
  output logic                     beat_write,
  output logic                     inv_valid,
  output logic [ADDR_W-PAGE_W-1:0] inv_page,
  output logic                     done,
  input  logic                     rd_valid,
  input  logic [1:0]               rd_kind,
  input  logic [1:0]               rd_lane,
  input  logic [31:0]              rd_word,
  output logic                     rx_valid,
  output logic [31:0]              rx_data
);
  import v64_xlate_pkg::*;

  logic [V64_LEN_W-1:0] cmd_len;
  logic                 unused_hi_bits;

  assign cmd_len        = kind_len(v64_kind_e'(cmd_kind));
  assign unused_hi_bits = ^cmd_addr[31:ADDR_W];

  v64_beat_gen #(.ADDR_W(ADDR_W), .LEN_W(V64_LEN_W), .PAGE_W(PAGE_W)) gen_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr[ADDR_W-1:0]),
    .cmd_len    (cmd_len),
    .cmd_write  (cmd_write),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_waddr (beat_waddr),
    .beat_be    (beat_be),
    .beat_last  (beat_last),
    .beat_write (beat_write),
    .inv_valid  (inv_valid),
    .inv_page   (inv_page),
    .done       (done)
  );

  v64_sext #(.DATA_W(32)) sext_i (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .rd_kind  (rd_kind),
    .rd_lane  (rd_lane),
    .rd_word  (rd_word),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );
endmodule

// File: tb/v64_vram_xlate_tb_top.sv
`timescale 1ns/100ps
module v64_vram_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'd0;
  logic [31:0] cmd_addr = 32'd0;
  logic        cmd_write = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [20:0] beat_waddr;
  logic [3:0]  beat_be;
  logic        beat_last;
  logic        beat_write;
  logic        inv_valid;
  logic [10:0] inv_page;
  logic        done;
  logic        rd_valid = 1'b0;
  logic [1:0]  rd_kind = 2'd0;
  logic [1:0]  rd_lane = 2'd0;
  logic [31:0] rd_word = 32'd0;
  logic        rx_valid;
  logic [31:0] rx_data;

  always #2.5 clk = ~clk;

  v64_vram_xlate dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_write(cmd_write),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_waddr(beat_waddr),
    .beat_be(beat_be), .beat_last(beat_last), .beat_write(beat_write),
    .inv_valid(inv_valid), .inv_page(inv_page), .done(done),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_lane(rd_lane), .rd_word(rd_word),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  typedef struct { int waddr; int be; bit last; bit wr; string req; } beat_t;
  beat_t exp_q[$];
  int    page_q[$];

  int  n_checks = 0;
  int  n_errors = 0;
  int  n_cmds = 0;
  int  n_done = 0;
  bit  running = 1'b0;
  bit  finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Driver: builds expected beats and pages from the requirements, then offers the command
  task automatic send(int kind, int unsigned addr, bit wr, string req);
    int unsigned a;
    int len, cur_word, prev_page;
    beat_t b;
    len = (kind == 0) ? 1 : (kind == 1) ? 2 : (kind == 2) ? 4 : 32;
    a = addr & 32'h7FFFFF;                       // R2
    if (a + len > 32'h800000) len = 32'h800000 - a; // R8
    cur_word = -1;
    prev_page = -1;
    b = '{waddr: 0, be: 0, last: 1'b0, wr: wr, req: req};
    for (int i = 0; i < len; i++) begin
      int unsigned ua;
      ua = a + i;
      if (int'(ua >> 2) != cur_word) begin
        if (cur_word != -1) exp_q.push_back(b);
        cur_word = int'(ua >> 2);
        b.waddr = int'((((ua >> 2) & 1) << 20) | ((ua >> 3) & 32'hFFFFF)); // R3
        b.be = 0;
      end
      b.be = b.be | (1 << (ua & 3));
      if (wr && int'(ua >> 12) != prev_page) begin
        prev_page = int'(ua >> 12);
        page_q.push_back(prev_page);               // R10
      end
    end
    b.last = 1'b1;
    exp_q.push_back(b);
    n_cmds++;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_kind  = kind[1:0];
    cmd_addr  = addr;
    cmd_write = wr;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: stall pattern, beat scoreboard, invalidate and done checks
  logic [7:0] lfsr = 8'hA5;
  bit         prev_stall = 1'b0;
  int         h_waddr = 0;
  int         h_be = 0;
  bit         pend_done = 1'b0;

  always @(negedge clk) begin
    if (running) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      beat_ready = lfsr[0] | lfsr[2];
      if (prev_stall)
        chk(beat_valid && int'(beat_waddr) == h_waddr && int'(beat_be) == h_be,
            "R9", "beat held under stall", int'(beat_waddr), h_waddr);
      if (pend_done || done) chk(done == pend_done, "R9", "done pulse", int'(done), int'(pend_done));
      if (done) n_done++;
      pend_done = 1'b0;
      prev_stall = beat_valid && !beat_ready;
      h_waddr = int'(beat_waddr);
      h_be = int'(beat_be);
      if (inv_valid) begin
        if (page_q.size() == 0) chk(1'b0, "R10", "unexpected invalidate", int'(inv_page), -1);
        else begin
          int p;
          p = page_q.pop_front();
          chk(int'(inv_page) == p, "R10", "invalidate page", int'(inv_page), p);
        end
      end
      if (beat_valid && beat_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected beat", int'(beat_waddr), -1);
        else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(int'(beat_waddr) == e.waddr, e.req, "beat word address", int'(beat_waddr), e.waddr);
          chk(int'(beat_be) == e.be, e.req, "beat lanes", int'(beat_be), e.be);
          chk(beat_last == e.last, e.req, "beat last flag", int'(beat_last), int'(e.last));
          chk(beat_write == e.wr, e.req, "beat direction", int'(beat_write), int'(e.wr));
        end
        pend_done = beat_last;
      end
    end
  end

  task automatic sx(int kind, int lane, int unsigned word);
    int unsigned exp;
    if (kind == 0) exp = unsigned'(int'($signed(8'((word >> (8 * lane)) & 8'hFF))));
    else if (kind == 1) exp = unsigned'(int'($signed(16'((word >> (16 * (lane / 2))) & 16'hFFFF))));
    else exp = word;
    @(negedge clk);
    rd_kind = kind[1:0];
    rd_lane = lane[1:0];
    rd_word = word;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rx_valid == 1'b1, "R11", "rx_valid one cycle later", int'(rx_valid), 1);
    chk(rx_data == exp, "R11", "extended read data", int'(rx_data), int'(exp));
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    chk(beat_valid == 1'b0, "R1", "beat_valid after reset", int'(beat_valid), 0);
    chk(inv_valid == 1'b0 && done == 1'b0, "R1", "strobes after reset", int'({inv_valid, done}), 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
    running = 1'b1;

    send(2, 32'h0000_0010, 1'b0, "R3");            // aligned word, bank 0
    send(2, 32'h0000_0014, 1'b1, "R3");            // bank 1, write
    send(0, 32'hAB12_3457, 1'b1, "R2");            // junk high bits
    send(1, 32'h0000_0103, 1'b1, "R4");            // halfword split across words
    send(2, 32'h0040_0006, 1'b0, "R6");            // unaligned word split
    send(3, 32'h0000_0200, 1'b1, "R5");            // aligned burst, alternating banks
    send(3, 32'h0000_0FF6, 1'b1, "R10");           // burst over a page boundary
    send(3, 32'h0034_5671, 1'b0, "R7");            // unaligned read burst, tail lanes
    send(3, 32'h007F_FFF0, 1'b1, "R8");            // clamped at end of memory
    send(3, 32'h017F_FFFD, 1'b0, "R8");            // clamp to 3 bytes
    send(1, 32'h007F_FFFF, 1'b1, "R8");            // halfword clamped to 1 byte
    send(3, 32'h0012_3002, 1'b1, "R6");            // write burst, unaligned head

    for (int w = 0; w < 400 && (exp_q.size() != 0 || !cmd_ready); w++) @(negedge clk);
    repeat (3) @(negedge clk);
    running = 1'b0;
    chk(exp_q.size() == 0, "R4", "all beats produced", exp_q.size(), 0);
    chk(page_q.size() == 0, "R10", "all pages invalidated", page_q.size(), 0);
    chk(n_done == n_cmds, "R9", "done pulse per command", n_done, n_cmds);

    sx(0, 0, 32'h80F1_7F82);
    sx(0, 1, 32'h80F1_7F82);
    sx(0, 3, 32'h80F1_7F82);
    sx(1, 0, 32'h80F1_7F82);
    sx(1, 2, 32'h80F1_7F82);
    sx(1, 2, 32'h7FFF_0000);
    sx(2, 1, 32'hDEAD_BEEF);

    finish_run();
  end
endmodule